// File: doc/BRIEF.md
# DAC Bus Write Sequencer

This block sits between a host and a bank of four double-buffered DAC channels. The DAC channels share one parallel data bus, a channel address and two active-low strobes. One strobe writes the staging register of the addressed channel. The other strobe copies all staging registers into the output registers at once. The host hands over channel writes and update requests on simple valid/ready ports. The sequencer then turns each request into a bus cycle whose address setup, strobe width, data hold and load-pulse width meet the converter's minimum timing. It measures every interval in cycles of its own clock, and derives each count from a nanosecond minimum and the clock period.

The block has two operating modes. In double-buffered mode, writes leave the load strobe high and so change only the staging registers. A separate update request then fires one load pulse that moves all four channels together. In single-buffered mode, the load strobe stays low, so the output registers are transparent and each write reaches its output directly. The block applies a mode change only when it is idle. When it leaves single-buffered mode, it keeps the load strobe low for a full load-pulse width after the last write before it lets the strobe rise.

Top module: `dac_wr_seq`

## Requirements
- R1: During reset and on its release, the write strobe and the load strobe are both high, both ready outputs are high, and the block is in double-buffered mode.
- R2: After a write is accepted on a clock edge, the write strobe falls SETUP_CYC cycles later (default 1). It then stays low for WR_CYC cycles, which is the larger of the 50 ns strobe width and the 45 ns data setup rounded up to whole clock periods (13 cycles at 4 ns).
- R3: `dac_a` carries the channel number in binary (0 to 3) and `dac_db` carries the data word. Both are valid from the first cycle after acceptance. Both stay unchanged while the write strobe is low and for HOLD_CYC cycles after it rises (10 ns rounded up, 3 cycles at 4 ns).
- R4: `wr_ready` goes low at acceptance and stays low for SETUP_CYC + WR_CYC + HOLD_CYC cycles (17 by default). It is high again in the cycle after the hold ends.
- R5: In double-buffered mode, the load strobe stays high throughout every write. An accepted update drives it low for exactly LD_CYC cycles (50 ns rounded up, 13 cycles at 4 ns), and both ready outputs are low during the pulse.
- R6: When a write and an update are requested in the same idle cycle, the write goes first and `upd_ready` is low while `wr_valid` is high. An update that is pending during a write is accepted on the first idle cycle after the hold, and its load pulse starts on the following cycle.
- R7: In single-buffered mode (`single_buf` = 1), the load strobe is low at all times, writes included. An accepted update leaves the load strobe low and the write strobe high.
- R8: When `single_buf` falls, the load strobe stays low for LD_CYC cycles counted from the first idle cycle, and the ready outputs stay low in that time. If a write is in flight, the count begins only after its hold. So the load strobe never rises within LD_CYC cycles after the write strobe rises.
- R9: A rise of `single_buf` takes effect only in an idle cycle. Both ready outputs are low while the input disagrees with the applied mode, and the load strobe is low from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| single_buf | input | 1 | 1 selects single-buffered mode, 0 selects double-buffered mode |
| wr_valid | input | 1 | Host offers a channel write |
| wr_ready | output | 1 | Sequencer can take a write this cycle |
| wr_chan | input | CHAN_W | Channel to write |
| wr_data | input | DATA_W | Word to write |
| upd_valid | input | 1 | Host requests a load of all channels |
| upd_ready | output | 1 | Sequencer can take an update this cycle |
| dac_db | output | DATA_W | Shared data bus to the converters |
| dac_a | output | CHAN_W | Channel address to the converters |
| dac_wr_n | output | 1 | Active-low write strobe |
| dac_ld_n | output | 1 | Active-low load strobe |

## Verification
The hardest case to reach is a mode drop from single-buffered to double-buffered while a write is still on the bus. In that case, the load strobe has been low across the write strobe's rising edge and must stay low for a full pulse width past the end of the hold. The bench sets up this case by starting a write in single-buffered mode and clearing `single_buf` two cycles after acceptance. It then follows the load strobe and `wr_ready` cycle by cycle until the deferred release. A second hard case is a pending update queued behind a write, which the bench creates by raising both valids in the same idle cycle.

// File: rtl/dws_pkg.sv
package dws_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_STROBE = 3'd2,
    ST_HOLD   = 3'd3,
    ST_LOAD   = 3'd4
  } dws_state_e;

  // Whole clock cycles that cover a minimum time, never fewer than one.
  function automatic int cyc_from_ns(input int ns, input int period_ps);
    int c;
    c = (ns * 1000 + period_ps - 1) / period_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dws_interval.sv
// Down counter that times one sequencer state.
module dws_interval #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/dws_ctrl.sv
// Request arbitration, mode application and state sequencing.
module dws_ctrl
  import dws_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int WR_CYC    = 13,
  parameter int HOLD_CYC  = 3,
  parameter int LD_CYC    = 13,
  parameter int CW        = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          single_buf,
  input  logic          wr_valid,
  input  logic          upd_valid,
  input  logic          tmr_zero,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          cap_en,
  output logic          wr_ready,
  output logic          upd_ready,
  output dws_state_e    state_nxt,
  output logic          mode_nxt
);

  dws_state_e state_q;
  logic       mode_q;
  logic       idle_ok;

  assign idle_ok   = (state_q == ST_IDLE) && (mode_q == single_buf);
  assign wr_ready  = idle_ok;
  assign upd_ready = idle_ok && !wr_valid;

  always_comb begin
    state_nxt = state_q;
    mode_nxt  = mode_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    cap_en    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (mode_q != single_buf) begin
          mode_nxt = single_buf;
          if (!single_buf) begin
            // leaving transparency: keep load low for a full pulse width
            state_nxt = ST_LOAD;
            tmr_load  = 1'b1;
            tmr_val   = CW'(LD_CYC - 1);
          end
        end else if (wr_valid) begin
          cap_en    = 1'b1;
          state_nxt = ST_SETUP;
          tmr_load  = 1'b1;
          tmr_val   = CW'(SETUP_CYC - 1);
        end else if (upd_valid && !mode_q) begin
          state_nxt = ST_LOAD;
          tmr_load  = 1'b1;
          tmr_val   = CW'(LD_CYC - 1);
        end
      end
      ST_SETUP: if (tmr_zero) begin
        state_nxt = ST_STROBE;
        tmr_load  = 1'b1;
        tmr_val   = CW'(WR_CYC - 1);
      end
      ST_STROBE: if (tmr_zero) begin
        state_nxt = ST_HOLD;
        tmr_load  = 1'b1;
        tmr_val   = CW'(HOLD_CYC - 1);
      end
      ST_HOLD:  if (tmr_zero) state_nxt = ST_IDLE;
      ST_LOAD:  if (tmr_zero) state_nxt = ST_IDLE;
      default:  state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_nxt;
      mode_q  <= mode_nxt;
    end
  end

endmodule

// File: rtl/dws_bus_drv.sv
// Registered bus and strobe outputs toward the converters.
module dws_bus_drv
  import dws_pkg::*;
#(
  parameter int CHAN_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic [DATA_W-1:0] data_i,
  input  dws_state_e        state_nxt,
  input  logic              mode_nxt,
  output logic [CHAN_W-1:0] dac_a,
  output logic [DATA_W-1:0] dac_db,
  output logic              dac_wr_n,
  output logic              dac_ld_n
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_a  <= '0;
      dac_db <= '0;
    end else if (cap_en) begin
      dac_a  <= chan_i;
      dac_db <= data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_wr_n <= 1'b1;
      dac_ld_n <= 1'b1;
    end else begin
      dac_wr_n <= (state_nxt != ST_STROBE);
      dac_ld_n <= !((state_nxt == ST_LOAD) || mode_nxt);
    end
  end

endmodule

// File: rtl/dac_wr_seq.sv
module dac_wr_seq
  import dws_pkg::*;
#(
  parameter int CHAN_W         = 2,
  parameter int DATA_W         = 8,
  parameter int CLK_PERIOD_PS  = 4000,
  parameter int ADDR_SETUP_CYC = 1,
  parameter int DATA_SETUP_NS  = 45,
  parameter int WR_PULSE_NS    = 50,
  parameter int DATA_HOLD_NS   = 10,
  parameter int LD_PULSE_NS    = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              single_buf,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [CHAN_W-1:0] wr_chan,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              upd_valid,
  output logic              upd_ready,
  output logic [DATA_W-1:0] dac_db,
  output logic [CHAN_W-1:0] dac_a,
  output logic              dac_wr_n,
  output logic              dac_ld_n
);

  localparam int SETUP_CYC = (ADDR_SETUP_CYC < 1) ? 1 : ADDR_SETUP_CYC;
  localparam int WR_CYC    = imax(cyc_from_ns(WR_PULSE_NS, CLK_PERIOD_PS),
                                  cyc_from_ns(DATA_SETUP_NS, CLK_PERIOD_PS));
  localparam int HOLD_CYC  = cyc_from_ns(DATA_HOLD_NS, CLK_PERIOD_PS);
  localparam int LD_CYC    = cyc_from_ns(LD_PULSE_NS, CLK_PERIOD_PS);
  localparam int MAX_CYC   = imax(imax(SETUP_CYC, WR_CYC), imax(HOLD_CYC, LD_CYC));
  localparam int CW        = $clog2(MAX_CYC + 1);

  // reset: asserted at once, released after two clock edges
  logic rst_meta_q;
  logic rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_zero;
  logic          cap_en;
  dws_state_e    state_nxt;
  logic          mode_nxt;

  dws_interval #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_q),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  dws_ctrl #(
    .SETUP_CYC (SETUP_CYC),
    .WR_CYC    (WR_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .LD_CYC    (LD_CYC),
    .CW        (CW)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_q),
    .single_buf (single_buf),
    .wr_valid   (wr_valid),
    .upd_valid  (upd_valid),
    .tmr_zero   (tmr_zero),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .cap_en     (cap_en),
    .wr_ready   (wr_ready),
    .upd_ready  (upd_ready),
    .state_nxt  (state_nxt),
    .mode_nxt   (mode_nxt)
  );

  dws_bus_drv #(.CHAN_W(CHAN_W), .DATA_W(DATA_W)) u_drv (
    .clk       (clk),
    .rst_n     (rst_q),
    .cap_en    (cap_en),
    .chan_i    (wr_chan),
    .data_i    (wr_data),
    .state_nxt (state_nxt),
    .mode_nxt  (mode_nxt),
    .dac_a     (dac_a),
    .dac_db    (dac_db),
    .dac_wr_n  (dac_wr_n),
    .dac_ld_n  (dac_ld_n)
  );

endmodule

// File: rtl/dws_checker.sv
module dws_checker #(
  parameter int CHAN_W = 2,
  parameter int DATA_W = 8,
  parameter int WR_CYC = 13,
  parameter int LD_CYC = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CHAN_W-1:0] dac_a,
  input logic [DATA_W-1:0] dac_db,
  input logic              dac_wr_n,
  input logic              dac_ld_n,
  input logic              wr_ready,
  input logic              upd_ready
);

  logic [15:0] wr_low_q;   // consecutive cycles with write strobe low
  logic [15:0] ld_low_q;   // consecutive cycles with load strobe low
  logic [15:0] wr_high_q;  // cycles since write strobe last low

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_low_q  <= '0;
      ld_low_q  <= '0;
      wr_high_q <= '1;
    end else begin
      wr_low_q  <= dac_wr_n ? '0 : ((wr_low_q == '1) ? wr_low_q : wr_low_q + 1'b1);
      ld_low_q  <= dac_ld_n ? '0 : ((ld_low_q == '1) ? ld_low_q : ld_low_q + 1'b1);
      wr_high_q <= !dac_wr_n ? '0 : ((wr_high_q == '1) ? wr_high_q : wr_high_q + 1'b1);
    end
  end

  a_r2_wr_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_wr_n) |-> (wr_low_q == 16'(WR_CYC)));

  a_r3_bus_stable_low: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_wr_n |-> ($stable(dac_a) && $stable(dac_db)));

  a_r3_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_wr_n) |=> ($stable(dac_a) && $stable(dac_db)));

  a_r4_ready_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_wr_n |-> (!wr_ready && !upd_ready));

  a_r5_ld_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_ld_n) |-> (ld_low_q >= 16'(LD_CYC)));

  a_r8_ld_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_ld_n) |-> (wr_high_q >= 16'(LD_CYC)));

endmodule

bind dac_wr_seq dws_checker #(
  .CHAN_W (CHAN_W),
  .DATA_W (DATA_W),
  .WR_CYC (WR_CYC),
  .LD_CYC (LD_CYC)
) u_dws_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .dac_a     (dac_a),
  .dac_db    (dac_db),
  .dac_wr_n  (dac_wr_n),
  .dac_ld_n  (dac_ld_n),
  .wr_ready  (wr_ready),
  .upd_ready (upd_ready)
);

// File: tb/tb_dac_wr_seq.sv
`timescale 1ns/1ps
module tb_dac_wr_seq;

  localparam int PER_PS = 4000;
  localparam int SU  = 1;
  localparam int WRC = ((50000 + PER_PS - 1) / PER_PS > (45000 + PER_PS - 1) / PER_PS)
                       ? (50000 + PER_PS - 1) / PER_PS : (45000 + PER_PS - 1) / PER_PS;
  localparam int HD  = (10000 + PER_PS - 1) / PER_PS;
  localparam int LD  = (50000 + PER_PS - 1) / PER_PS;
  localparam int TOT = SU + WRC + HD;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       single_buf = 1'b0;
  logic       wr_valid = 1'b0;
  logic       upd_valid = 1'b0;
  logic [1:0] wr_chan = '0;
  logic [7:0] wr_data = '0;
  logic       wr_ready, upd_ready, dac_wr_n, dac_ld_n;
  logic [7:0] dac_db;
  logic [1:0] dac_a;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dac_wr_seq dut (
    .clk(clk), .rst_n(rst_n), .single_buf(single_buf),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_chan(wr_chan), .wr_data(wr_data),
    .upd_valid(upd_valid), .upd_ready(upd_ready),
    .dac_db(dac_db), .dac_a(dac_a), .dac_wr_n(dac_wr_n), .dac_ld_n(dac_ld_n)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", rq, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // R1: strobes and readies after reset
  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(dac_wr_n == 1'b1, "R1", "wr_n in reset", dac_wr_n, 1);
    chk(dac_ld_n == 1'b1, "R1", "ld_n in reset", dac_ld_n, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(dac_wr_n == 1'b1 && dac_ld_n == 1'b1, "R1", "strobes after reset",
        {dac_wr_n, dac_ld_n}, 3);
    chk(wr_ready && upd_ready, "R1", "readies after reset", {wr_ready, upd_ready}, 3);
  endtask

  // R2 R3 R4 plus load level during the write
  task automatic t_write(input logic [1:0] ch, input logic [7:0] d,
                         input logic exp_ld, input string ldrq);
    wr_chan = ch; wr_data = d; wr_valid = 1'b1;
    #1;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    for (int j = 0; j <= TOT + 1; j++) begin
      chk(dac_wr_n == ((j >= SU && j < SU + WRC) ? 1'b0 : 1'b1), "R2", "wr_n",
          dac_wr_n, (j >= SU && j < SU + WRC) ? 0 : 1);
      chk(wr_ready == (j >= TOT), "R4", "wr_ready", wr_ready, (j >= TOT) ? 1 : 0);
      if (j <= TOT)
        chk({dac_a, dac_db} == {ch, d}, "R3", "addr/data", {dac_a, dac_db}, {ch, d});
      chk(dac_ld_n == exp_ld, ldrq, "ld_n during write", dac_ld_n, exp_ld);
      @(negedge clk);
    end
  endtask

  // R5: one load pulse in double-buffered mode
  task automatic t_update();
    upd_valid = 1'b1;
    #1;
    chk(upd_ready == 1'b1, "R5", "upd_ready idle", upd_ready, 1);
    @(negedge clk);
    upd_valid = 1'b0;
    for (int j = 0; j <= LD + 1; j++) begin
      chk(dac_ld_n == (j >= LD), "R5", "ld_n pulse", dac_ld_n, (j >= LD) ? 1 : 0);
      chk(upd_ready == (j >= LD) && wr_ready == (j >= LD), "R5", "readies in pulse",
          {wr_ready, upd_ready}, (j >= LD) ? 3 : 0);
      chk(dac_wr_n == 1'b1, "R5", "wr_n during load", dac_wr_n, 1);
      @(negedge clk);
    end
  endtask

  // R6: simultaneous requests, write first, update queued
  task automatic t_priority();
    wr_chan = 2'd2; wr_data = 8'h3C; wr_valid = 1'b1; upd_valid = 1'b1;
    #1;
    chk(wr_ready && !upd_ready, "R6", "write wins", {wr_ready, upd_ready}, 2);
    @(negedge clk);
    wr_valid = 1'b0;
    for (int j = 0; j <= TOT + LD + 1; j++) begin
      if (j == TOT) chk(upd_ready == 1'b1, "R6", "upd_ready after hold", upd_ready, 1);
      if (j > 0 && j < TOT) chk(upd_ready == 1'b0, "R6", "upd waits", upd_ready, 0);
      if (j == TOT + 1) upd_valid = 1'b0;
      chk(dac_ld_n == !(j >= TOT + 1 && j <= TOT + LD), "R6", "queued ld_n",
          dac_ld_n, (j >= TOT + 1 && j <= TOT + LD) ? 0 : 1);
      chk(dac_wr_n == !(j >= SU && j < SU + WRC), "R6", "wr_n", dac_wr_n,
          (j >= SU && j < SU + WRC) ? 0 : 1);
      @(negedge clk);
    end
  endtask

  // R9: entering single-buffered mode
  task automatic t_enter_single();
    single_buf = 1'b1;
    #1;
    chk(!wr_ready && !upd_ready, "R9", "readies during mismatch",
        {wr_ready, upd_ready}, 0);
    @(negedge clk);
    chk(dac_ld_n == 1'b0, "R9", "ld_n low after entry", dac_ld_n, 0);
    chk(wr_ready && upd_ready, "R9", "readies after entry", {wr_ready, upd_ready}, 3);
  endtask

  // R7: update has no effect in single-buffered mode
  task automatic t_single_update();
    upd_valid = 1'b1;
    #1;
    chk(upd_ready == 1'b1, "R7", "upd_ready single", upd_ready, 1);
    @(negedge clk);
    upd_valid = 1'b0;
    for (int j = 0; j <= LD + 2; j++) begin
      chk(dac_ld_n == 1'b0 && dac_wr_n == 1'b1, "R7", "strobes after update",
          {dac_wr_n, dac_ld_n}, 2);
      chk(upd_ready == 1'b1, "R7", "upd_ready stays", upd_ready, 1);
      @(negedge clk);
    end
  endtask

  // R8: leaving single-buffered mode while idle
  task automatic t_leave_idle();
    single_buf = 1'b0;
    @(negedge clk);
    for (int j = 0; j <= LD + 1; j++) begin
      chk(dac_ld_n == (j >= LD), "R8", "ld_n release", dac_ld_n, (j >= LD) ? 1 : 0);
      chk(wr_ready == (j >= LD), "R8", "wr_ready release", wr_ready, (j >= LD) ? 1 : 0);
      @(negedge clk);
    end
  endtask

  // R8: leaving single-buffered mode with a write in flight
  task automatic t_leave_in_flight();
    wr_chan = 2'd1; wr_data = 8'hC3; wr_valid = 1'b1;
    #1;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    for (int j = 0; j <= TOT + LD + 2; j++) begin
      if (j == 2) single_buf = 1'b0;
      #1;
      chk(dac_ld_n == (j > TOT + LD), "R8", "deferred ld_n", dac_ld_n,
          (j > TOT + LD) ? 1 : 0);
      chk(wr_ready == (j > TOT + LD), "R8", "deferred ready", wr_ready,
          (j > TOT + LD) ? 1 : 0);
      chk(dac_wr_n == !(j >= SU && j < SU + WRC), "R8", "wr_n", dac_wr_n,
          (j >= SU && j < SU + WRC) ? 0 : 1);
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_write(2'd0, 8'h00, 1'b1, "R5");
    t_write(2'd3, 8'hFF, 1'b1, "R5");
    t_write(2'd1, 8'hA5, 1'b1, "R5");
    t_update();
    t_priority();
    t_write(2'd2, 8'h5A, 1'b1, "R5");
    t_enter_single();
    t_write(2'd3, 8'h81, 1'b0, "R7");
    t_single_update();
    t_leave_idle();
    t_enter_single();
    t_leave_in_flight();
    t_update();
    summary();
    $finish;
  end

endmodule